// File: doc/BRIEF.md
# Background Tile Row Fetcher

This block feeds the background side of a scanline renderer. While drawing is enabled it walks a fixed sequence of steps. It reads a tile number and its attribute byte from a tile map, reads the two bit-plane bytes of one tile row, and then drops eight 2-bit pixels into a 16-entry pixel queue. Each pixel carries its colour and a palette and a priority field. The renderer downstream pops pixels from the head of the queue, one per cycle at most.

The fetcher works out which map entry to read from four inputs: the scroll values, the current line, and a window flag. When the window is active it uses a window line input and an internal window column counter instead. The tile-data address comes from an unsigned or signed base. When a read is blocked, the value used is all ones. A window start or a new drawing period empties the queue and sends the sequencer back to its first step.

Top module: `tile_row_fetcher`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `fifo_level` is 0 and `px_valid` is 0. Fetch column and window column are 0, and `vram_addr` shows the map address of the first step (0x9800 when all scroll and line inputs are 0 and `bg_map_sel` is 0).
- R2: While `run` is high, the sequencer spends 2 cycles each on these steps, in this order: map read, low-byte read, high-byte read, idle. It then enters the push step. While `run` is low the step does not change.
- R3: A push writes 8 pixels and happens only when `fifo_level` is 0. It is attempted on the last cycle of the high-byte step; if that succeeds the next step is the map read. If it does not, the push step retries every cycle until the queue is empty. After a push, the fetch column advances by 1 (modulo 32).
- R4: Outside the window, the map entry address is base + row*32 + col. Here row = ((`ly` + `scroll_y`) mod 256) / 8 and col = (`scroll_col` + fetch column) mod 32.
- R5: The map base is 0x9C00 when `bg_map_sel` is 1 outside the window, or when `win_map_sel` is 1 inside it. Otherwise it is 0x9800.
- R6: Inside the window, the map row comes from `win_line`/8 and the column from a window column counter. That counter resets on `win_start` or `draw_start` and advances by 1 on each push made while `in_window` is 1.
- R7: The low-byte address is B + idx*16 + r*2, and the high-byte address is that plus 1. B is 0x8000 with idx unsigned when `tile_data_unsigned` is 1, or 0x9000 with idx taken as signed 8-bit when it is 0. r = line mod 8, replaced by 7 - r when the attribute vertical-flip bit is set.
- R8: A read taken while `vram_blocked` is 1 yields 0xFF for the tile index and for both data bytes, and all ones for the attribute.
- R9: Pixel k of a row (k = 0 first out) has colour {hi[b], lo[b]}. b = 7 - k normally, and b = k when the horizontal-flip bit is set. Attribute layout: bit 5 priority, bit 4 vertical flip, bit 3 horizontal flip, bits 2:0 palette. Each pixel copies the palette and priority.
- R10: A cycle with `win_start` or `draw_start` high empties the queue by the next cycle and returns the step to the map read. `draw_start` also clears the fetch column.
- R11: `px_pop` with a non-empty queue removes the head pixel and lowers `fifo_level` by 1. `px_pop` on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| draw_start | input | 1 | Pulse: start of a drawing period |
| win_start | input | 1 | Pulse: window begins on this line |
| run | input | 1 | Sequencer advances while high |
| in_window | input | 1 | Current fetch is a window tile |
| scroll_col | input | 5 | Coarse horizontal scroll (scroll X divided by 8) |
| scroll_y | input | 8 | Vertical scroll |
| ly | input | 8 | Current scanline |
| win_line | input | 8 | Current window line |
| bg_map_sel | input | 1 | Upper tile map for background |
| win_map_sel | input | 1 | Upper tile map for window |
| tile_data_unsigned | input | 1 | 1: unsigned data base 0x8000, 0: signed base 0x9000 |
| vram_addr | output | 16 | Video memory read address |
| vram_data | input | 8 | Read data (index or bit-plane byte) |
| vram_attr | input | 6 | Attribute read at the same address |
| vram_blocked | input | 1 | Read access blocked; value taken as all ones |
| px_pop | input | 1 | Remove head pixel |
| px_valid | output | 1 | Queue not empty |
| px_color | output | 2 | Head pixel colour |
| px_pal | output | 3 | Head pixel palette |
| px_prio | output | 1 | Head pixel priority |
| fifo_level | output | 5 | Number of queued pixels |

## Verification
The hardest case to reach is the early push at the end of the high-byte step. The queue must be exactly empty on that one cycle, so the bench pops every cycle for long stretches, and it also runs a directed start from an empty queue where the first row must land six cycles after the start. The opposite case is a queue that stays full while the push step waits. The bench covers it by holding pops off and then draining with sparse pop patterns, so pushes fall on arbitrary retry cycles. Window starts are issued while pixels are still queued, and blocked reads and `run` stalls are toggled partway through fetches.

// File: rtl/trf_pkg.sv
package trf_pkg;

    localparam int TILE_W = 8;

    localparam logic [15:0] MAP_BASE_LO   = 16'h9800;
    localparam logic [15:0] MAP_BASE_HI   = 16'h9C00;
    localparam logic [15:0] DATA_BASE_UNS = 16'h8000;
    localparam logic [15:0] DATA_BASE_SGN = 16'h9000;
    localparam logic [7:0]  BLOCKED_BYTE  = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDX_A,
        ST_IDX_B,
        ST_LO_A,
        ST_LO_B,
        ST_HI_A,
        ST_HI_B,
        ST_IDLE_A,
        ST_IDLE_B,
        ST_PUSH
    } step_e;

    typedef struct packed {
        logic       prio;
        logic       vflip;
        logic       hflip;
        logic [2:0] pal;
    } attr_t;

    typedef struct packed {
        logic       prio;
        logic [2:0] pal;
        logic [1:0] color;
    } pixel_t;

    function automatic logic [15:0] map_base(input logic upper);
        return upper ? MAP_BASE_HI : MAP_BASE_LO;
    endfunction

    function automatic pixel_t make_pixel(input logic [7:0] lo,
                                          input logic [7:0] hi,
                                          input attr_t      at,
                                          input logic [2:0] slot);
        pixel_t     p;
        logic [2:0] b;
        b       = at.hflip ? slot : ~slot;
        p.prio  = at.prio;
        p.pal   = at.pal;
        p.color = {hi[b], lo[b]};
        return p;
    endfunction

endpackage

// File: rtl/trf_addr_gen.sv
module trf_addr_gen
    import trf_pkg::*;
(
    input  step_e       step,
    input  logic [4:0]  scroll_col,
    input  logic [7:0]  scroll_y,
    input  logic [7:0]  ly,
    input  logic [7:0]  win_line,
    input  logic        in_window,
    input  logic [4:0]  fetch_x,
    input  logic [4:0]  win_col,
    input  logic        bg_map_sel,
    input  logic        win_map_sel,
    input  logic        data_unsigned,
    input  logic [7:0]  tile_idx,
    input  logic        vflip,
    output logic [15:0] vram_addr
);

    logic [7:0]  ypos;
    logic [4:0]  col;
    logic [2:0]  row;
    logic [15:0] map_addr;
    logic [15:0] tile_off;
    logic [15:0] lo_addr;

    always_comb begin
        ypos     = in_window ? win_line : 8'(ly + scroll_y);
        col      = in_window ? win_col : 5'(scroll_col + fetch_x);
        map_addr = map_base(in_window ? win_map_sel : bg_map_sel)
                 + {6'd0, ypos[7:3], col};
        row      = vflip ? ~ypos[2:0] : ypos[2:0];
        tile_off = data_unsigned ? {4'd0, tile_idx, 4'd0}
                                 : {{4{tile_idx[7]}}, tile_idx, 4'd0};
        lo_addr  = (data_unsigned ? DATA_BASE_UNS : DATA_BASE_SGN)
                 + tile_off + {12'd0, row, 1'b0};
        case (step)
            ST_LO_A, ST_LO_B: vram_addr = lo_addr;
            ST_HI_A, ST_HI_B: vram_addr = lo_addr + 16'd1;
            default:          vram_addr = map_addr;
        endcase
    end

endmodule

// File: rtl/trf_fetch_seq.sv
module trf_fetch_seq
    import trf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       draw_start,
    input  logic       win_start,
    input  logic       run,
    input  logic       in_window,
    input  logic       fifo_empty,
    input  logic [7:0] rd_data,
    input  logic [5:0] rd_attr,
    input  logic       rd_blocked,
    output step_e      step,
    output logic [7:0] tile_idx,
    output attr_t      attr,
    output logic [7:0] row_lo,
    output logic [7:0] row_hi,
    output logic       push,
    output logic [4:0] fetch_x,
    output logic [4:0] win_col
);

    step_e      step_q;
    step_e      step_nx;
    logic [7:0] tile_idx_q;
    attr_t      attr_q;
    logic [7:0] lo_q;
    logic [7:0] hi_q;
    logic [4:0] fetch_x_q;
    logic [4:0] win_col_q;
    logic [7:0] data_eff;
    attr_t      attr_eff;
    logic       restart;
    logic       push_slot;

    always_comb begin
        restart   = draw_start | win_start;
        data_eff  = rd_blocked ? BLOCKED_BYTE : rd_data;
        attr_eff  = rd_blocked ? attr_t'('1) : attr_t'(rd_attr);
        push_slot = (step_q == ST_HI_B) || (step_q == ST_PUSH);
        push      = run & ~restart & fifo_empty & push_slot;
        row_hi    = (step_q == ST_HI_B) ? data_eff : hi_q;
    end

    always_comb begin
        case (step_q)
            ST_IDX_A:  step_nx = ST_IDX_B;
            ST_IDX_B:  step_nx = ST_LO_A;
            ST_LO_A:   step_nx = ST_LO_B;
            ST_LO_B:   step_nx = ST_HI_A;
            ST_HI_A:   step_nx = ST_HI_B;
            ST_HI_B:   step_nx = push ? ST_IDX_A : ST_IDLE_A;
            ST_IDLE_A: step_nx = ST_IDLE_B;
            ST_IDLE_B: step_nx = ST_PUSH;
            ST_PUSH:   step_nx = push ? ST_IDX_A : ST_PUSH;
            default:   step_nx = ST_IDX_A;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q     <= ST_IDX_A;
            tile_idx_q <= '0;
            attr_q     <= '0;
            lo_q       <= '0;
            hi_q       <= '0;
            fetch_x_q  <= '0;
            win_col_q  <= '0;
        end else if (draw_start) begin
            step_q    <= ST_IDX_A;
            fetch_x_q <= '0;
            win_col_q <= '0;
        end else if (win_start) begin
            step_q    <= ST_IDX_A;
            win_col_q <= '0;
        end else if (run) begin
            step_q <= step_nx;
            if (step_q == ST_IDX_B) begin
                tile_idx_q <= data_eff;
                attr_q     <= attr_eff;
            end
            if (step_q == ST_LO_B) begin
                lo_q <= data_eff;
            end
            if (step_q == ST_HI_B) begin
                hi_q <= data_eff;
            end
            if (push) begin
                fetch_x_q <= fetch_x_q + 5'd1;
                if (in_window) begin
                    win_col_q <= win_col_q + 5'd1;
                end
            end
        end
    end

    assign step     = step_q;
    assign tile_idx = tile_idx_q;
    assign attr     = attr_q;
    assign row_lo   = lo_q;
    assign fetch_x  = fetch_x_q;
    assign win_col  = win_col_q;

endmodule

// File: rtl/trf_pix_fifo.sv
module trf_pix_fifo
    import trf_pkg::*;
#(
    parameter  int DEPTH   = 16,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int LEVEL_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               push,
    input  pixel_t             row [TILE_W],
    input  logic               pop,
    output pixel_t             head,
    output logic [LEVEL_W-1:0] level,
    output logic               empty
);

    pixel_t             mem [DEPTH];
    logic [PTR_W-1:0]   rd_ptr;
    logic [LEVEL_W-1:0] level_q;
    logic               pop_ok;

    initial begin
        if ((1 << PTR_W) != DEPTH || DEPTH < TILE_W) begin
            $error("trf_pix_fifo: DEPTH must be a power of two of at least one row");
        end
    end

    assign empty  = (level_q == '0);
    assign pop_ok = pop & ~empty;
    assign level  = level_q;
    assign head   = empty ? pixel_t'('0) : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            level_q <= '0;
            rd_ptr  <= '0;
        end else if (push) begin
            level_q <= LEVEL_W'(TILE_W);
        end else if (pop_ok) begin
            level_q <= level_q - 1'b1;
            rd_ptr  <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !rst && !clr) begin
            for (int i = 0; i < TILE_W; i++) begin
                mem[PTR_W'(rd_ptr + PTR_W'(i))] <= row[i];
            end
        end
    end

endmodule

// File: rtl/tile_row_fetcher.sv
module tile_row_fetcher
    import trf_pkg::*;
#(
    parameter  int FIFO_DEPTH = 16,
    localparam int LEVEL_W    = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               draw_start,
    input  logic               win_start,
    input  logic               run,
    input  logic               in_window,
    input  logic [4:0]         scroll_col,
    input  logic [7:0]         scroll_y,
    input  logic [7:0]         ly,
    input  logic [7:0]         win_line,
    input  logic               bg_map_sel,
    input  logic               win_map_sel,
    input  logic               tile_data_unsigned,
    output logic [15:0]        vram_addr,
    input  logic [7:0]         vram_data,
    input  logic [5:0]         vram_attr,
    input  logic               vram_blocked,
    input  logic               px_pop,
    output logic               px_valid,
    output logic [1:0]         px_color,
    output logic [2:0]         px_pal,
    output logic               px_prio,
    output logic [LEVEL_W-1:0] fifo_level
);

    step_e      cur_step;
    logic [7:0] tile_idx;
    attr_t      attr;
    logic [7:0] row_lo;
    logic [7:0] row_hi;
    logic       push;
    logic [4:0] fetch_x;
    logic [4:0] win_col;
    logic       fifo_empty;
    logic       fifo_clr;
    pixel_t     row_pix [TILE_W];
    pixel_t     head;

    assign fifo_clr = draw_start | win_start;

    trf_fetch_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .draw_start (draw_start),
        .win_start  (win_start),
        .run        (run),
        .in_window  (in_window),
        .fifo_empty (fifo_empty),
        .rd_data    (vram_data),
        .rd_attr    (vram_attr),
        .rd_blocked (vram_blocked),
        .step       (cur_step),
        .tile_idx   (tile_idx),
        .attr       (attr),
        .row_lo     (row_lo),
        .row_hi     (row_hi),
        .push       (push),
        .fetch_x    (fetch_x),
        .win_col    (win_col)
    );

    trf_addr_gen u_addr (
        .step          (cur_step),
        .scroll_col    (scroll_col),
        .scroll_y      (scroll_y),
        .ly            (ly),
        .win_line      (win_line),
        .in_window     (in_window),
        .fetch_x       (fetch_x),
        .win_col       (win_col),
        .bg_map_sel    (bg_map_sel),
        .win_map_sel   (win_map_sel),
        .data_unsigned (tile_data_unsigned),
        .tile_idx      (tile_idx),
        .vflip         (attr.vflip),
        .vram_addr     (vram_addr)
    );

    for (genvar g = 0; g < TILE_W; g++) begin : g_row
        assign row_pix[g] = make_pixel(row_lo, row_hi, attr, 3'(g));
    end

    trf_pix_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (fifo_clr),
        .push  (push),
        .row   (row_pix),
        .pop   (px_pop),
        .head  (head),
        .level (fifo_level),
        .empty (fifo_empty)
    );

    assign px_valid = ~fifo_empty;
    assign px_color = head.color;
    assign px_pal   = head.pal;
    assign px_prio  = head.prio;

endmodule

// File: rtl/trf_checker.sv
module trf_checker
    import trf_pkg::*;
#(
    parameter  int FIFO_DEPTH = 16,
    localparam int LEVEL_W    = $clog2(FIFO_DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               draw_start,
    input logic               win_start,
    input logic               run,
    input logic               px_pop,
    input logic               px_valid,
    input logic [LEVEL_W-1:0] fifo_level,
    input step_e              cur_step
);

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (fifo_level == '0 && !px_valid)); // R1

    AST_PUSH_FROM_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (fifo_level > $past(fifo_level)) |->
            ($past(fifo_level) == '0 && fifo_level == LEVEL_W'(TILE_W))); // R3

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
        (fifo_level == LEVEL_W'(TILE_W) && $past(fifo_level) == '0) |->
            ($past(cur_step) == ST_HI_B || $past(cur_step) == ST_PUSH)); // R3

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (draw_start || win_start) |=> (fifo_level == '0 && cur_step == ST_IDX_A)); // R10

    AST_POP_ONE: assert property (@(posedge clk) disable iff (rst)
        (px_valid && px_pop && !draw_start && !win_start) |=>
            (fifo_level == $past(fifo_level) - 1'b1)); // R11

    AST_PUSH_WAITS: assert property (@(posedge clk) disable iff (rst)
        (cur_step == ST_PUSH && px_valid && run && !draw_start && !win_start) |=>
            (cur_step == ST_PUSH)); // R2

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!run && !draw_start && !win_start) |=> $stable(cur_step)); // R2

endmodule

bind tile_row_fetcher trf_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .draw_start (draw_start),
    .win_start  (win_start),
    .run        (run),
    .px_pop     (px_pop),
    .px_valid   (px_valid),
    .fifo_level (fifo_level),
    .cur_step   (cur_step)
);

// File: tb/sim_tile_row_fetcher.sv
`timescale 1ns/1ps
module sim_tile_row_fetcher;

    localparam real HALF = 10.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        draw_start = 1'b0;
    logic        win_start = 1'b0;
    logic        run = 1'b0;
    logic        in_window = 1'b0;
    logic [4:0]  scroll_col = '0;
    logic [7:0]  scroll_y = '0;
    logic [7:0]  ly = '0;
    logic [7:0]  win_line = '0;
    logic        bg_map_sel = 1'b0;
    logic        win_map_sel = 1'b0;
    logic        tile_data_unsigned = 1'b1;
    logic        vram_blocked = 1'b0;
    logic        px_pop = 1'b0;
    logic [15:0] vram_addr;
    logic [7:0]  vram_data;
    logic [5:0]  vram_attr;
    logic        px_valid;
    logic [1:0]  px_color;
    logic [2:0]  px_pal;
    logic        px_prio;
    logic [4:0]  fifo_level;

    int nchk = 0;
    int nfail = 0;
    bit checking = 0;
    bit finished = 0;
    int pop_mode = 0;
    int cyc = 0;

    always #(HALF) clk = ~clk;

    function automatic logic [7:0] vdata(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    function automatic logic [5:0] vattr(input logic [15:0] a);
        return {a[3] ^ a[9], a[4] ^ a[1], a[2] ^ a[6], a[7:5]};
    endfunction

    assign vram_data = vdata(vram_addr);
    assign vram_attr = vattr(vram_addr);

    tile_row_fetcher u0 (
        .clk(clk), .rst(rst), .draw_start(draw_start), .win_start(win_start),
        .run(run), .in_window(in_window), .scroll_col(scroll_col),
        .scroll_y(scroll_y), .ly(ly), .win_line(win_line),
        .bg_map_sel(bg_map_sel), .win_map_sel(win_map_sel),
        .tile_data_unsigned(tile_data_unsigned), .vram_addr(vram_addr),
        .vram_data(vram_data), .vram_attr(vram_attr),
        .vram_blocked(vram_blocked), .px_pop(px_pop), .px_valid(px_valid),
        .px_color(px_color), .px_pal(px_pal), .px_prio(px_prio),
        .fifo_level(fifo_level)
    );

    // Behavioural reference model
    int         mstep = 0;
    int         mfx = 0;
    int         mwc = 0;
    logic [7:0] midx = '0;
    logic [5:0] mattr = '0;
    logic [7:0] mlo = '0;
    logic [7:0] mhi = '0;
    logic [5:0] mq [$];

    function automatic int model_addr(input int st);
        int ypos, col, base, row, idx, lo;
        ypos = in_window ? int'(win_line) : (int'(ly) + int'(scroll_y)) % 256;
        col  = in_window ? mwc % 32 : (int'(scroll_col) + mfx) % 32;
        base = (in_window ? win_map_sel : bg_map_sel) ? 'h9C00 : 'h9800;
        row  = ypos % 8;
        if (mattr[4]) row = 7 - row;
        idx  = int'(midx);
        if (tile_data_unsigned) lo = 'h8000 + idx * 16 + row * 2;
        else lo = 'h9000 + ((idx >= 128) ? idx - 256 : idx) * 16 + row * 2;
        lo = lo & 'hFFFF;
        if (st == 2 || st == 3) return lo;
        if (st == 4 || st == 5) return (lo + 1) & 'hFFFF;
        return base + (ypos / 8) * 32 + col;
    endfunction

    task automatic model_push();
        for (int s = 0; s < 8; s++) begin
            int b;
            b = mattr[3] ? s : 7 - s;
            mq.push_back({mattr[5], mattr[2:0], mhi[b], mlo[b]});
        end
        mfx = (mfx + 1) % 32;
        if (in_window) mwc = (mwc + 1) % 32;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mstep = 0; mfx = 0; mwc = 0;
            midx = '0; mattr = '0; mlo = '0; mhi = '0;
            mq.delete();
        end else if (draw_start) begin
            mstep = 0; mfx = 0; mwc = 0;
            mq.delete();
        end else if (win_start) begin
            mstep = 0; mwc = 0;
            mq.delete();
        end else begin
            bit         was_empty;
            int         a;
            logic [7:0] d;
            logic [5:0] at;
            was_empty = (mq.size() == 0);
            if (px_pop && !was_empty) void'(mq.pop_front());
            if (run) begin
                a  = model_addr(mstep);
                d  = vram_blocked ? 8'hFF : vdata(16'(a));
                at = vram_blocked ? 6'h3F : vattr(16'(a));
                case (mstep)
                    1: begin midx = d; mattr = at; mstep = 2; end
                    3: begin mlo = d; mstep = 4; end
                    5: begin
                        mhi = d;
                        if (was_empty) begin model_push(); mstep = 0; end
                        else mstep = 6;
                    end
                    8: if (was_empty) begin model_push(); mstep = 0; end
                    default: mstep = mstep + 1;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edges
    always @(negedge clk) begin
        #(HALF / 2);
        if (checking && !finished) begin
            if (mstep >= 2 && mstep <= 5)
                chk("R2 R7 data address", 32'(vram_addr), 32'(model_addr(mstep)));
            else if (in_window)
                chk("R6 R5 window map address", 32'(vram_addr), 32'(model_addr(mstep)));
            else
                chk("R4 R5 map address", 32'(vram_addr), 32'(model_addr(mstep)));
            chk("R2 R3 R11 level", 32'(fifo_level), 32'(mq.size()));
            chk("R11 valid", 32'(px_valid), 32'(mq.size() != 0));
            if (mq.size() != 0)
                chk("R8 R9 head pixel", 32'({px_prio, px_pal, px_color}), 32'(mq[0]));
        end
    end

    // Pop pattern driver
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            case (pop_mode)
                1: px_pop = 1'b1;
                2: px_pop = (cyc % 3 == 0);
                3: px_pop = (cyc % 7 < 3);
                default: px_pop = 1'b0;
            endcase
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_draw();
        draw_start = 1'b1;
        @(negedge clk);
        draw_start = 1'b0;
    endtask

    task automatic pulse_win();
        win_start = 1'b1;
        in_window = 1'b1;
        @(negedge clk);
        win_start = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired (R2 R3 sequencing hung)");
            finish_run();
        end
    end

    initial begin
        wait_cycles(4);
        chk("R1 reset level", 32'(fifo_level), 32'd0);
        chk("R1 reset valid", 32'(px_valid), 32'd0);
        chk("R1 reset address", 32'(vram_addr), 32'h9800);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 level after reset", 32'(fifo_level), 32'd0);
        checking = 1;

        // Early push from an empty queue: row lands after six steps of two-cycle fetch
        scroll_col = 5'd5; scroll_y = 8'h13; ly = 8'h40;
        run = 1'b1;
        pulse_draw();
        wait_cycles(5);
        chk("R3 no push before high-byte step ends", 32'(fifo_level), 32'd0);
        wait_cycles(1);
        chk("R3 early push of one row", 32'(fifo_level), 32'd8);
        wait_cycles(40);
        chk("R3 push waits while queue not empty", 32'(fifo_level), 32'd8);
        pop_mode = 2;
        wait_cycles(300);

        // Upper map, signed data, continuous popping (early pushes)
        for (int k = 0; k < 4; k++) begin
            bg_map_sel = 1'b1; tile_data_unsigned = 1'b0;
            scroll_col = 5'(29 + k * 3); scroll_y = 8'(8'hF0 + k * 37); ly = 8'(k * 50 + 3);
            pop_mode = 1;
            pulse_draw();
            wait_cycles(200);
        end

        // Blocked reads toggled mid-fetch
        pop_mode = 3; bg_map_sel = 1'b0; tile_data_unsigned = 1'b1;
        pulse_draw();
        for (int k = 0; k < 20; k++) begin
            vram_blocked = (k % 3 != 2);
            wait_cycles(7 + k % 4);
        end
        vram_blocked = 1'b0;

        // Window start with pixels still queued
        pop_mode = 0;
        wait_cycles(30);
        win_line = 8'h21; win_map_sel = 1'b1;
        pulse_win();
        chk("R10 window start empties queue", 32'(fifo_level), 32'd0);
        pop_mode = 2;
        wait_cycles(250);
        pop_mode = 1;
        wait_cycles(150);

        // Stalls while fetching
        pop_mode = 3;
        for (int k = 0; k < 15; k++) begin
            run = 1'b0;
            wait_cycles(1 + k % 3);
            run = 1'b1;
            wait_cycles(3 + k % 5);
        end

        // Back to background with a new drawing period, window map inactive
        in_window = 1'b0; win_map_sel = 1'b0; bg_map_sel = 1'b1;
        pulse_draw();
        chk("R10 draw start empties queue", 32'(fifo_level), 32'd0);
        wait_cycles(200);

        // Pops on an empty queue are ignored
        run = 1'b0;
        pop_mode = 1;
        wait_cycles(20);
        chk("R11 drained queue stays empty", 32'(fifo_level), 32'd0);
        wait_cycles(5);
        chk("R11 pop on empty has no effect", 32'(px_valid), 32'd0);
        pop_mode = 0;
        run = 1'b1;
        wait_cycles(20);

        finish_run();
    end

endmodule